// File: doc/BRIEF.md
# Sigma-Delta Raw Bitstream Output Stage

This block sits at the output edge of a multichannel sigma-delta converter's digital core. In the normal readout formats it passes the decimation filter's serial data and ready strobe straight to the pins and leaves the serial clock pin as an input. One format-select code switches the block into raw bitstream mode. In that mode the decimation filter is told to shut down to save power, and each channel's single-bit modulator output is registered onto that channel's own data pin. The serial clock pin is turned around to an output that carries a divided copy of the master clock.

The divide ratio comes from the speed-mode input and the clock-divide select. Data pins change only on the master-clock edge where the generated clock falls, so an external filter can sample them on the rising edge. Any change to the speed mode or the divide select restarts the divider from a clean low phase, so no shortened pulse reaches the pin.

Top module: `sdm_bypass_out`

## Requirements
- R1: While rst_ni is low, sclk_o is 0 and every raw-data lane register is 0. With the raw code selected during reset, dout_o therefore reads all zeros.
- R2: When fmt_sel_i equals RAW_CODE (default 3'b110), sclk_oe_o is 1, filt_en_o is 0 and rdy_o is 0. For any other code, sclk_oe_o is 0, filt_en_o is 1, sclk_o is 0, dout_o equals filt_dout_i and rdy_o equals filt_rdy_i.
- R3: In raw mode, the period of sclk_o in master clocks is set as follows. speed_i 2'b00 or 2'b01 gives 4. speed_i 2'b10 gives 8 with div_sel_i=1 and 4 with div_sel_i=0. speed_i 2'b11 gives 40 with div_sel_i=1 and 8 with div_sel_i=0.
- R4: sclk_o has a 50% duty cycle: it is high for half the period and low for half the period, for example 20 and 20 master clocks at the 40 ratio.
- R5: In raw mode, dout_o changes only at the master edge where sclk_o falls. Bit k of dout_o takes bit k of mod_bits_i as it stood in the cycle before that edge.
- R6: When speed_i or div_sel_i differs from its value in the previous cycle, sclk_o is 0 in the next cycle. The new ratio's first rising edge comes half a period after that.
- R7: When raw mode is left, the lane registers clear on the next edge. sclk_o stays 0 for as long as raw mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_sel_i | input | 3 | Output format select; RAW_CODE picks raw bitstream mode |
| speed_i | input | 2 | Converter speed mode |
| div_sel_i | input | 1 | Clock-divide select |
| mod_bits_i | input | NCH | One modulator bit per channel |
| filt_dout_i | input | NCH | Filtered serial data from the readout logic |
| filt_rdy_i | input | 1 | Ready/frame strobe from the readout logic |
| dout_o | output | NCH | Per-channel data pins |
| sclk_o | output | 1 | Generated modulator clock (valid when sclk_oe_o=1) |
| sclk_oe_o | output | 1 | Serial clock pin drive enable |
| rdy_o | output | 1 | Ready/frame-sync pin |
| filt_en_o | output | 1 | Decimation filter enable |

## Verification
The bench runs all eight speed and divide combinations and measures the master clocks between rising edges of sclk_o. A wrong table entry or an off-by-one terminal count shows up as a wrong interval, most visibly at the divide-by-40 entry. It changes the configuration in the middle of a period and checks that a clean low phase follows: a design without the restart would emit a short pulse or keep the old phase. Each channel gets its own random bit pattern, so swapped lanes, or data that updates on the rising edge instead of the falling edge, are caught by the per-cycle comparison. Mode exits are also covered: a design that kept driving the clock or kept stale lane data after raw mode is left would fail those checks.

// File: rtl/sdm_out_pkg.sv
package sdm_out_pkg;
  localparam int unsigned MAX_RATIO = 40;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

  typedef logic [CNT_W-1:0] cnt_t;

  // Period in master clocks for a speed mode / divide select pair.
  function automatic cnt_t ratio_of(input logic [1:0] speed, input logic div_sel);
    cnt_t r;
    unique case (speed)
      2'b10:   r = div_sel ? cnt_t'(8)  : cnt_t'(4);
      2'b11:   r = div_sel ? cnt_t'(40) : cnt_t'(8);
      default: r = cnt_t'(4);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sdm_clk_div.sv
module sdm_clk_div
  import sdm_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] speed_i,
  input  logic       div_sel_i,
  output logic       sclk_o,
  output logic       fall_o
);
  cnt_t       cnt_q, cnt_d;
  logic       sclk_q, sclk_d;
  logic [2:0] cfg_q;
  logic       restart;
  cnt_t       ratio, half;

  assign ratio   = ratio_of(speed_i, div_sel_i);
  assign half    = ratio >> 1;
  assign restart = !run_i || (cfg_q != {speed_i, div_sel_i});
  assign fall_o  = !restart && (cnt_q == ratio - cnt_t'(1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (restart) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else begin
      cnt_d = (cnt_q == ratio - cnt_t'(1)) ? '0 : cnt_q + cnt_t'(1);
      if (cnt_q == half - cnt_t'(1)) sclk_d = 1'b1;
      if (fall_o)                    sclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      cfg_q  <= {speed_i, div_sel_i};
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/sdm_lane.sv
module sdm_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cap_i,
  input  logic bit_i,
  output logic bit_o
);
  logic q, d;

  always_comb begin
    d = q;
    if (clr_i)      d = 1'b0;
    else if (cap_i) d = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= d;
  end

  assign bit_o = q;
endmodule

// File: rtl/sdm_bypass_out.sv
module sdm_bypass_out #(
  parameter int unsigned NCH      = 8,
  parameter logic [2:0]  RAW_CODE = 3'b110
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     fmt_sel_i,
  input  logic [1:0]     speed_i,
  input  logic           div_sel_i,
  input  logic [NCH-1:0] mod_bits_i,
  input  logic [NCH-1:0] filt_dout_i,
  input  logic           filt_rdy_i,
  output logic [NCH-1:0] dout_o,
  output logic           sclk_o,
  output logic           sclk_oe_o,
  output logic           rdy_o,
  output logic           filt_en_o
);
  logic           raw;
  logic           sclk_int;
  logic           fall;
  logic [NCH-1:0] lane_q;

  assign raw = (fmt_sel_i == RAW_CODE);

  sdm_clk_div u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (raw),
    .speed_i   (speed_i),
    .div_sel_i (div_sel_i),
    .sclk_o    (sclk_int),
    .fall_o    (fall)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    sdm_lane u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!raw),
      .cap_i  (fall),
      .bit_i  (mod_bits_i[k]),
      .bit_o  (lane_q[k])
    );
  end

  assign dout_o    = raw ? lane_q : filt_dout_i;
  assign sclk_o    = raw & sclk_int;
  assign sclk_oe_o = raw;
  assign rdy_o     = raw ? 1'b0 : filt_rdy_i;
  assign filt_en_o = !raw;
endmodule

// File: rtl/sdm_bypass_out_chk.sv
module sdm_bypass_out_chk #(
  parameter int unsigned NCH      = 8,
  parameter logic [2:0]  RAW_CODE = 3'b110
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2:0]     fmt_sel_i,
  input logic [1:0]     speed_i,
  input logic           div_sel_i,
  input logic [NCH-1:0] dout_o,
  input logic           sclk_o,
  input logic           sclk_oe_o,
  input logic           rdy_o,
  input logic           filt_en_o
);
  logic       raw;
  logic [5:0] hi_run;
  assign raw = (fmt_sel_i == RAW_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_run <= '0;
    else if (sclk_o) hi_run <= hi_run + 6'd1;
    else             hi_run <= '0;
  end

  // R2
  raw_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw |-> (sclk_oe_o && !filt_en_o && !rdy_o));

  // R2
  norm_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw |-> (!sclk_o && !sclk_oe_o && filt_en_o));

  // R5
  dout_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw && $past(raw)) |-> ($stable(dout_o) || $fell(sclk_o)));

  // R6
  restart_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw && (speed_i != $past(speed_i) || div_sel_i != $past(div_sel_i))) |=> !sclk_o);

  // R4
  max_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run <= 6'd20);
endmodule

bind sdm_bypass_out sdm_bypass_out_chk #(.NCH(NCH), .RAW_CODE(RAW_CODE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fmt_sel_i (fmt_sel_i),
  .speed_i   (speed_i),
  .div_sel_i (div_sel_i),
  .dout_o    (dout_o),
  .sclk_o    (sclk_o),
  .sclk_oe_o (sclk_oe_o),
  .rdy_o     (rdy_o),
  .filt_en_o (filt_en_o)
);

// File: tb/sdm_bypass_out_tb.sv
module sdm_bypass_out_tb_top;
  localparam int  NCH      = 8;
  localparam time CLK_PER  = 10ns;
  localparam logic [2:0] RAW = 3'b110;

  logic           clk, rst_n;
  logic [2:0]     fmt;
  logic [1:0]     speed;
  logic           dsel;
  logic [NCH-1:0] mod_bits, filt_dout;
  logic           filt_rdy;
  logic [NCH-1:0] dout;
  logic           sclk, sclk_oe, rdy, filt_en;

  int checks = 0, errors = 0;
  int cyc = 0;
  int last_rise = -1;
  logic prev_sclk = 1'b0;

  // reference model state
  int             m_cnt = 0;
  logic [NCH-1:0] m_lane = '0;
  logic [2:0]     m_prev_cfg = '0;

  sdm_bypass_out #(.NCH(NCH), .RAW_CODE(RAW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fmt_sel_i(fmt), .speed_i(speed),
    .div_sel_i(dsel), .mod_bits_i(mod_bits), .filt_dout_i(filt_dout),
    .filt_rdy_i(filt_rdy), .dout_o(dout), .sclk_o(sclk), .sclk_oe_o(sclk_oe),
    .rdy_o(rdy), .filt_en_o(filt_en)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  function automatic int exp_ratio(input logic [1:0] s, input logic d);
    if (s == 2'b11) return d ? 40 : 8;
    if (s == 2'b10) return d ? 8 : 4;
    return 4;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each active edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lane = '0; m_prev_cfg = '0;
    end else begin
      if (fmt != RAW) begin
        m_cnt = 0; m_lane = '0;
      end else if ({speed, dsel} != m_prev_cfg) begin
        m_cnt = 0;
      end else if (m_cnt == exp_ratio(speed, dsel) - 1) begin
        m_cnt = 0; m_lane = mod_bits;
      end else begin
        m_cnt++;
      end
      m_prev_cfg = {speed, dsel};
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic raw_now, e_sclk;
    cyc++;
    raw_now = (fmt == RAW);
    e_sclk  = raw_now && (m_cnt >= exp_ratio(speed, dsel) / 2);
    if (!rst_n) begin
      chk("R1", "sclk in reset", sclk, 0);
      if (raw_now) chk("R1", "dout in reset", dout, 0);
    end else begin
      chk("R4", "sclk vs model", sclk, e_sclk);
      chk("R2", "sclk_oe", sclk_oe, raw_now);
      chk("R2", "filt_en", filt_en, !raw_now);
      if (raw_now) begin
        chk("R5", "raw lanes", dout, m_lane);
        chk("R2", "rdy in raw", rdy, 0);
      end else begin
        chk("R2", "dout pass", dout, filt_dout);
        chk("R2", "rdy pass", rdy, filt_rdy);
        chk("R7", "sclk off", sclk, 0);
      end
      if (raw_now && sclk && !prev_sclk) begin
        if (last_rise >= 0)
          chk("R3", "rise interval", cyc - last_rise, exp_ratio(speed, dsel));
        last_rise = cyc;
      end
    end
    prev_sclk = sclk;
    // drive new stimulus
    mod_bits  = NCH'($urandom);
    filt_dout = NCH'($urandom);
    filt_rdy  = 1'($urandom);
  end

  task automatic set_cfg(input logic [2:0] f, input logic [1:0] s, input logic d);
    @(negedge clk);
    #1;
    fmt = f; speed = s; dsel = d;
    last_rise = -1;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fmt = RAW; speed = 2'b00; dsel = 1'b1;
    mod_bits = '0; filt_dout = '0; filt_rdy = 1'b0;
    rst_n = 1'b0;
    // R1: reset state observed by the per-cycle compare
    wait_clks(4);
    @(negedge clk); #1 rst_n = 1'b1;
    wait_clks(40);
    // R2: normal formats pass through
    set_cfg(3'b000, 2'b11, 1'b1); wait_clks(30);
    set_cfg(3'b011, 2'b00, 1'b0); wait_clks(30);
    // R3 R4 R5: every ratio entry
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++) begin
        set_cfg(RAW, 2'(s), 1'(d));
        wait_clks(200);
      end
    // R6: change mid-period
    set_cfg(RAW, 2'b11, 1'b1); wait_clks(27);
    set_cfg(RAW, 2'b10, 1'b1); wait_clks(3);
    set_cfg(RAW, 2'b11, 1'b0); wait_clks(50);
    set_cfg(RAW, 2'b11, 1'b1); wait_clks(13);
    // R7: leave raw mode mid-period, then return
    set_cfg(3'b001, 2'b11, 1'b1); wait_clks(20);
    set_cfg(RAW, 2'b11, 1'b1); wait_clks(150);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule